// File: doc/BRIEF.md
# Cross-Clock Timer Register Write Bridge

This block is an 8-bit timer whose counter runs on a slow, free-running timer clock of around 32 kHz. Its counter, compare and control registers are written from a much faster system clock. Every system-side write first lands in a staging register owned by that register alone. The write then crosses into the timer domain and reaches its destination on the second rising edge of the timer clock. While a transfer is in flight, a per-register busy bit reads 1. Software polls it before it writes the same register again, or before it relies on the new value.

The timer either clears on compare or wraps freely. Each compare match raises a sticky flag in the system domain. Compare detection is held off while a counter or compare write is still pending, so the value that is being replaced cannot produce a false match. The system clock must run more than four times faster than the timer clock.

Top module: `xclk_timer_bridge`

## Requirements
- R1: After reset, rd_status reads 0 and tmr_count reads 0. The counter stays at 0 over later timer edges until a control write sets the run bit.
- R2: The write address map is 0 = counter, 1 = compare, 2 = control (bit 0 run, bit 1 clear-on-compare) and 3 = flag clear. rd_status bit 0, 1 and 2 is the busy bit of the counter, compare and control register. Bit 3 is the compare flag. An accepted write to register k sets busy bit k in the next system cycle.
- R3: An accepted write becomes effective in the timer domain on the second rising timer-clock edge after it, and not on the first.
- R4: A write to one register does not disturb a transfer that is pending on another. Two registers written back to back both reach their destinations.
- R5: A write to a register whose busy bit is 1 is ignored. The staged value and the later destination value stay those of the earlier write.
- R6: The busy bit stays 1 after the first timer edge. It returns to 0 through a two-flop system-clock synchronizer no later than 4 system cycles after the second timer edge.
- R7: In clear-on-compare mode the counter steps through TOP-1, TOP, 0, 1, where TOP is the compare value. The compare flag is set when the counter clears from TOP.
- R8: No compare match is detected on a timer edge at which a counter or compare write is still pending. The counter then simply increments.
- R9: The compare flag stays 1 until a write to address 3 with data bit 0 = 1 clears it. A write there with bit 0 = 0 leaves it set.
- R10: With clear-on-compare off, a match sets the flag but the counter keeps incrementing, and it wraps from 255 to 0.
- R11: With the run bit at 0, the counter holds its value on every timer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock |
| tmr_clk | input | 1 | Slow asynchronous timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | System-side write strobe |
| wr_addr | input | 2 | Write address (0 counter, 1 compare, 2 control, 3 flag clear) |
| wr_data | input | 8 | Write data |
| rd_status | output | 4 | {compare flag, control busy, compare busy, counter busy} |
| tmr_count | output | 8 | Current counter value, timer-clock domain |

## Verification
A lost or doubled request toggle leaves a busy bit stuck at 1, or lets a second write through. This is visible on rd_status within a few system cycles of the write and within two timer edges of it. A destination register that is loaded one edge early or late shows up directly on tmr_count at the edge in question. A missing block on compare detection shows as a counter cleared to 0 and a flag set at the edge where the counter should step past TOP. A broken flag crossing shows on rd_status bit 3 within a few system cycles of the clearing edge.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_CMP  = 2'd1,
    REG_CTL  = 2'd2,
    REG_FLAG = 2'd3
  } xtb_addr_e;

  localparam int unsigned NUM_CHAN    = 3;
  localparam int unsigned IDX_CNT     = 0;
  localparam int unsigned IDX_CMP     = 1;
  localparam int unsigned IDX_CTL     = 2;
  localparam int unsigned CTL_RUN_BIT = 0;
  localparam int unsigned CTL_CTC_BIT = 1;
  localparam int unsigned CTL_W       = 2;
endpackage

// File: rtl/xtb_bit_sync.sv
module xtb_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xtb_stage_chan.sv
module xtb_stage_chan #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          ack_tgl_async,
  output logic [DW-1:0] stage_o,
  output logic          req_tgl_o,
  output logic          busy_o
);
  logic [DW-1:0] stage_q, stage_d;
  logic          req_q, req_d;
  logic          ack_s;
  logic          accept;

  xtb_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_tgl_async),
    .q    (ack_s)
  );

  always_comb begin
    busy_o  = req_q ^ ack_s;
    accept  = wr_hit & ~busy_o;
    stage_d = accept ? wr_data : stage_q;
    req_d   = req_q ^ accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      req_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      req_q   <= req_d;
    end
  end

  assign stage_o   = stage_q;
  assign req_tgl_o = req_q;
endmodule

// File: rtl/xtb_timer_core.sv
module xtb_timer_core #(
  parameter int unsigned DW  = 8,
  parameter int unsigned NCH = 3
) (
  input  logic                    tclk,
  input  logic                    trst_n,
  input  logic [NCH-1:0]          req_tgl_async,
  input  logic [NCH-1:0][DW-1:0]  stage_async,
  output logic [NCH-1:0]          ack_tgl_o,
  output logic [DW-1:0]           count_o,
  output logic                    match_tgl_o
);
  import xtb_pkg::*;

  logic [NCH-1:0]   cap_q, ack_q, pend;
  logic [DW-1:0]    cnt_q, cnt_d;
  logic [DW-1:0]    cmp_q, cmp_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             match_q, match_d;
  logic             hit, block;
  logic             ctl_spare_unused;

  assign ctl_spare_unused = ^stage_async[IDX_CTL][DW-1:CTL_W];

  // first edge captures the request toggle, second edge commits it
  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cap_q <= '0;
      ack_q <= '0;
    end else begin
      cap_q <= req_tgl_async;
      ack_q <= cap_q;
    end
  end

  assign pend = cap_q ^ ack_q;

  always_comb begin
    cmp_d = pend[IDX_CMP] ? stage_async[IDX_CMP] : cmp_q;
    ctl_d = pend[IDX_CTL] ? stage_async[IDX_CTL][CTL_W-1:0] : ctl_q;
  end

  always_comb begin
    hit     = (cnt_q == cmp_q);
    block   = pend[IDX_CNT] | pend[IDX_CMP];
    cnt_d   = cnt_q;
    match_d = match_q;
    if (pend[IDX_CNT]) begin
      cnt_d = stage_async[IDX_CNT];
    end else if (ctl_q[CTL_RUN_BIT]) begin
      if (hit && !block) begin
        match_d = ~match_q;
        cnt_d   = ctl_q[CTL_CTC_BIT] ? '0 : cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cnt_q   <= '0;
      cmp_q   <= '0;
      ctl_q   <= '0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
      ctl_q   <= ctl_d;
      match_q <= match_d;
    end
  end

  assign ack_tgl_o   = ack_q;
  assign count_o     = cnt_q;
  assign match_tgl_o = match_q;
endmodule

// File: rtl/xtb_flag_sync.sv
module xtb_flag_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match_tgl_async,
  input  logic clr,
  output logic flag_o,
  output logic set_evt_o
);
  logic tgl_s, prev_q, flag_q, flag_d;

  xtb_bit_sync #(.STAGES(SYNC_STAGES)) u_match_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (match_tgl_async),
    .q    (tgl_s)
  );

  always_comb begin
    set_evt_o = tgl_s ^ prev_q;
    flag_d    = set_evt_o | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= tgl_s;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/xclk_timer_bridge.sv
module xclk_timer_bridge #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      sys_clk,
  input  logic                      tmr_clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [xtb_pkg::NUM_CHAN:0] rd_status,
  output logic [DW-1:0]             tmr_count
);
  import xtb_pkg::*;

  localparam int unsigned NCH = NUM_CHAN;

  logic                   sys_rst_n, tmr_rst_n;
  logic [NCH-1:0]         wr_hit, busy, req_tgl, ack_tgl;
  logic [NCH-1:0][DW-1:0] stage_w;
  logic                   match_tgl, flag, flag_clr, flag_set_evt;

  xtb_bit_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(sys_clk), .rst_n(rst_n), .d(1'b1), .q(sys_rst_n)
  );
  xtb_bit_sync #(.STAGES(SYNC_STAGES)) u_tmr_rst (
    .clk(tmr_clk), .rst_n(rst_n), .d(1'b1), .q(tmr_rst_n)
  );

  assign flag_clr = wr_en && (wr_addr == REG_FLAG) && wr_data[0];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign wr_hit[c] = wr_en && (wr_addr == 2'(c));
    xtb_stage_chan #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk          (sys_clk),
      .rst_n        (sys_rst_n),
      .wr_hit       (wr_hit[c]),
      .wr_data      (wr_data),
      .ack_tgl_async(ack_tgl[c]),
      .stage_o      (stage_w[c]),
      .req_tgl_o    (req_tgl[c]),
      .busy_o       (busy[c])
    );
  end

  xtb_timer_core #(.DW(DW), .NCH(NCH)) u_core (
    .tclk         (tmr_clk),
    .trst_n       (tmr_rst_n),
    .req_tgl_async(req_tgl),
    .stage_async  (stage_w),
    .ack_tgl_o    (ack_tgl),
    .count_o      (tmr_count),
    .match_tgl_o  (match_tgl)
  );

  xtb_flag_sync #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
    .clk            (sys_clk),
    .rst_n          (sys_rst_n),
    .match_tgl_async(match_tgl),
    .clr            (flag_clr),
    .flag_o         (flag),
    .set_evt_o      (flag_set_evt)
  );

  assign rd_status = {flag, busy};
endmodule

// File: rtl/xclk_timer_bridge_chk.sv
module xclk_timer_bridge_chk #(
  parameter int unsigned DW = 8
) (
  input logic          sys_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          clr_bit,
  input logic [3:0]    rd_status,
  input logic [DW-1:0] stage_cnt,
  input logic          set_evt
);
  AST_BUSY_SET_CNT: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && !rd_status[0]) |=> rd_status[0]); // R2
  AST_BUSY_SET_CMP: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !rd_status[1]) |=> rd_status[1]); // R2
  AST_BUSY_SET_CTL: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !rd_status[2]) |=> rd_status[2]); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && rd_status[0]) |=> $stable(stage_cnt)); // R5
  AST_FLAG_STICKY: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (rd_status[3] && !(wr_en && wr_addr == 2'd3 && clr_bit)) |=> rd_status[3]); // R9
  AST_FLAG_CLEARED: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && clr_bit && !set_evt) |=> !rd_status[3]); // R9
endmodule

module xtb_core_chk #(
  parameter int unsigned DW = 8
) (
  input logic          tclk,
  input logic          rst_n,
  input logic          pend_cnt,
  input logic          pend_cmp,
  input logic [1:0]    ctl,
  input logic [DW-1:0] count,
  input logic [DW-1:0] cmp,
  input logic [DW-1:0] stage_cnt
);
  AST_COUNT_LOAD: assert property (@(posedge tclk) disable iff (!rst_n)
    pend_cnt |=> (count == $past(stage_cnt))); // R3
  AST_MATCH_BLOCKED: assert property (@(posedge tclk) disable iff (!rst_n)
    (pend_cmp && !pend_cnt && ctl[0]) |=> (count == $past(count) + 1'b1)); // R8
  AST_CTC_CLEAR: assert property (@(posedge tclk) disable iff (!rst_n)
    (!pend_cnt && !pend_cmp && ctl == 2'b11 && count == cmp) |=> (count == '0)); // R7
  AST_STOPPED_HOLD: assert property (@(posedge tclk) disable iff (!rst_n)
    (!ctl[0] && !pend_cnt) |=> $stable(count)); // R11
endmodule

bind xclk_timer_bridge xclk_timer_bridge_chk #(.DW(DW)) i_sys_chk (
  .sys_clk  (sys_clk),
  .rst_n    (sys_rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .clr_bit  (wr_data[0]),
  .rd_status(rd_status),
  .stage_cnt(stage_w[0]),
  .set_evt  (flag_set_evt)
);

bind xtb_timer_core xtb_core_chk #(.DW(DW)) i_core_chk (
  .tclk     (tclk),
  .rst_n    (trst_n),
  .pend_cnt (pend[0]),
  .pend_cmp (pend[1]),
  .ctl      (ctl_q),
  .count    (cnt_q),
  .cmp      (cmp_q),
  .stage_cnt(stage_async[0])
);

// File: tb/test_xclk_timer_bridge.sv
`timescale 1ns/100ps
module test_xclk_timer_bridge;
  localparam int DW = 8;

  logic          sys_clk;
  logic          tmr_clk;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [3:0]    rd_status;
  logic [DW-1:0] tmr_count;

  xclk_timer_bridge #(.DW(DW)) i_xclk_timer_bridge (
    .sys_clk  (sys_clk),
    .tmr_clk  (tmr_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_status(rd_status),
    .tmr_count(tmr_count)
  );

  // 200 MHz system clock; timer clock period 170 ns (ratio 34)
  initial begin
    sys_clk = 1'b0;
    forever #2.5 sys_clk = ~sys_clk;
  end
  initial begin
    tmr_clk = 1'b0;
    #40;
    forever begin
      tmr_clk = 1'b1; #85;
      tmr_clk = 1'b0; #85;
    end
  end

  typedef struct {
    int        kind;   // 0: rd_status, 1: tmr_count
    logic [7:0] exp;
    string     tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_err = 0;
  int n_push = 0;
  int n_done = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    item_t it;
    logic [7:0] act;
    forever begin
      wait (q.size() > 0);
      it  = q.pop_front();
      act = (it.kind == 0) ? {4'b0000, rd_status} : tmr_count;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
      end
      n_done++;
    end
  end

  task automatic expect_item(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
    n_push++;
    wait (n_done == n_push);
  endtask

  task automatic sys_write(logic [1:0] a, logic [7:0] d);
    @(negedge sys_clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge sys_clk);
    wr_en   = 1'b0;
  endtask

  task automatic tmr_step();
    @(posedge tmr_clk);
    @(negedge tmr_clk);
  endtask

  task automatic wait_idle(string tag);
    int k;
    k = 0;
    while (rd_status[2:0] != 3'b000 && k < 4000) begin
      @(negedge sys_clk);
      k++;
    end
    if (k >= 4000) begin
      n_chk++;
      n_err++;
      $display("FAIL %s: actual busy %0h expected 0", tag, rd_status[2:0]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge sys_clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 2'd0;
    wr_data = '0;
    repeat (20) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (3) @(posedge tmr_clk);
    @(negedge tmr_clk);
    expect_item(0, 8'h00, "R1 reset status");
    expect_item(1, 8'h00, "R1 reset count");
    repeat (3) tmr_step();
    expect_item(1, 8'h00, "R1 stopped after reset");

    // R2 R3 R6: single counter write and its timing
    @(posedge tmr_clk);
    sys_write(2'd0, 8'h2A);
    expect_item(0, 8'h01, "R2 counter busy set");
    @(negedge tmr_clk);
    expect_item(1, 8'h00, "R3 before first edge");
    tmr_step();
    expect_item(1, 8'h00, "R3 unchanged after first edge");
    expect_item(0, 8'h01, "R6 busy held after first edge");
    @(posedge tmr_clk);
    repeat (4) @(negedge sys_clk);
    expect_item(0, 8'h00, "R6 busy cleared after second edge");
    @(negedge tmr_clk);
    expect_item(1, 8'h2A, "R3 loaded on second edge");

    // R5: write while busy is ignored
    @(posedge tmr_clk);
    sys_write(2'd0, 8'd10);
    sys_write(2'd0, 8'd200);
    expect_item(0, 8'h01, "R5 busy during ignored write");
    wait_idle("R5 idle");
    @(negedge tmr_clk);
    expect_item(1, 8'd10, "R5 first value kept");

    // R4: back-to-back writes to two registers
    @(posedge tmr_clk);
    sys_write(2'd1, 8'd5);
    sys_write(2'd0, 8'd3);
    expect_item(0, 8'h03, "R4 both busy");
    wait_idle("R4 idle");
    @(negedge tmr_clk);
    expect_item(1, 8'd3, "R4 counter landed");

    // R7: clear-on-compare with TOP = 5
    sys_write(2'd3, 8'h01);
    @(posedge tmr_clk);
    sys_write(2'd2, 8'h03);
    @(posedge tmr_clk);
    tmr_step();
    expect_item(1, 8'd3, "R7 start value");
    tmr_step();
    expect_item(1, 8'd4, "R7 TOP-1");
    tmr_step();
    expect_item(1, 8'd5, "R7 TOP");
    expect_item(0, 8'h00, "R7 flag clear before wrap");
    tmr_step();
    expect_item(1, 8'd0, "R7 BOTTOM");
    expect_item(0, 8'h08, "R7 flag set on clear");
    tmr_step();
    expect_item(1, 8'd1, "R7 BOTTOM+1");

    // R9: sticky flag, clear by writing 1
    sys_write(2'd3, 8'h00);
    expect_item(0, 8'h08, "R9 write 0 keeps flag");
    sys_write(2'd3, 8'h01);
    expect_item(0, 8'h00, "R9 write 1 clears flag");

    // R8: compare write pending at the edge where count == TOP
    repeat (3) @(posedge tmr_clk);
    @(negedge tmr_clk);
    expect_item(1, 8'd4, "R8 at TOP-1");
    sys_write(2'd1, 8'd200);
    tmr_step();
    expect_item(1, 8'd5, "R8 at TOP");
    tmr_step();
    expect_item(1, 8'd6, "R8 no clear while pending");
    expect_item(0, 8'h00, "R8 no flag while pending");

    // R11: stop the counter
    sys_write(2'd2, 8'h00);
    tmr_step();
    expect_item(1, 8'd7, "R11 still running on first edge");
    tmr_step();
    expect_item(1, 8'd8, "R11 last increment");
    repeat (3) tmr_step();
    expect_item(1, 8'd8, "R11 held while stopped");

    // R10: free-running mode, match without clear, wrap at 255
    sys_write(2'd3, 8'h01);
    @(posedge tmr_clk);
    sys_write(2'd0, 8'd253);
    sys_write(2'd1, 8'd254);
    wait_idle("R10 idle");
    @(posedge tmr_clk);
    sys_write(2'd2, 8'h01);
    @(posedge tmr_clk);
    tmr_step();
    expect_item(1, 8'd253, "R10 start value");
    tmr_step();
    expect_item(1, 8'd254, "R10 at compare");
    expect_item(0, 8'h00, "R10 flag before match");
    tmr_step();
    expect_item(1, 8'd255, "R10 no clear on match");
    expect_item(0, 8'h08, "R10 flag on match");
    tmr_step();
    expect_item(1, 8'd0, "R10 wrap to zero");
    tmr_step();
    expect_item(1, 8'd1, "R10 after wrap");

    finish_run();
  end
endmodule